// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Flags and Self-Clearing Flush

This block holds two byte queues that sit between a register-bus side and a serial bit engine. The transmit queue is filled by the bus and drained by the engine. The receive queue is filled by the engine and drained by the bus. Each queue reports its fill level through registered flags: empty, full, a threshold flag, and a sticky overrun.

The transmit queue has a nearly-empty threshold flag, so software knows when to top it up. The receive queue has a nearly-full threshold flag, so software knows when to drain it. Both thresholds are 4-bit inputs, so the largest value they can take is 15.

Each queue can be flushed on its own. A one-cycle request raises a busy indication that software can read back. While busy is high, the queue ignores every push and pop. After a fixed number of cycles the queue comes back empty and busy clears without any further action.

Top module: `byte_fifo_pair`

## Requirements
- R1: After a synchronous reset, both empty flags read 1. Full, threshold, overrun and flush-busy outputs all read 0.
- R2: Each queue returns bytes in the order they were written. The read-data output is registered and shows the popped byte from the clock edge that accepts the pop. A push and a pop in the same cycle are both accepted, and the occupancy does not change.
- R3: The empty flag is 1 exactly when the occupancy is 0. The full flag is 1 exactly when the occupancy is 16. A pop from an empty queue is ignored.
- R4: A push into a full queue is discarded and the stored bytes stay unchanged. A pop in the same cycle as that push is still accepted.
- R5: A push into a full queue sets that queue's overrun flag. The flag stays set until a cycle with the clear-overrun input high and no new overrun. A new overrun in the same cycle wins over the clear.
- R6: The transmit nearly-empty flag is 1 when the occupancy is at least 1 and no greater than the transmit threshold.
- R7: The receive nearly-full flag is 1 when the occupancy is at least 1 and no less than the receive threshold.
- R8: A one-cycle flush request makes that queue's busy output 1 from the next edge for FLUSH_CYC cycles. Busy then returns to 0 on its own. The two queues flush independently.
- R9: While a queue's flush is busy, pushes and pops on both of its sides are ignored. The read-data output holds its value, and a repeated flush request has no effect.
- R10: When a flush finishes, that queue's empty flag is 1 and its full and threshold flags are 0. The next byte pushed is also the next byte popped.
- R11: All flags are registered. A change in occupancy or threshold shows on the flags after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_thresh | input | 4 | Transmit nearly-empty threshold |
| rx_thresh | input | 4 | Receive nearly-full threshold |
| bus_tx_push | input | 1 | Bus pushes a byte into the transmit queue |
| bus_tx_data | input | 8 | Byte pushed by the bus |
| eng_tx_pop | input | 1 | Engine pops a byte from the transmit queue |
| eng_tx_data | output | 8 | Registered byte popped by the engine |
| eng_rx_push | input | 1 | Engine pushes a byte into the receive queue |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| bus_rx_pop | input | 1 | Bus pops a byte from the receive queue |
| bus_rx_data | output | 8 | Registered byte popped by the bus |
| flush_tx_req | input | 1 | One-cycle request to flush the transmit queue |
| flush_rx_req | input | 1 | One-cycle request to flush the receive queue |
| flush_tx_busy | output | 1 | Transmit flush in progress (self-clearing) |
| flush_rx_busy | output | 1 | Receive flush in progress (self-clearing) |
| ovr_clr | input | 1 | Clears both overrun flags |
| tx_empty | output | 1 | Transmit queue empty |
| tx_near_empty | output | 1 | Transmit occupancy in range 1..tx_thresh |
| tx_full | output | 1 | Transmit queue full |
| tx_overrun | output | 1 | Sticky transmit overrun |
| rx_empty | output | 1 | Receive queue empty |
| rx_near_full | output | 1 | Receive occupancy at least max(1, rx_thresh) |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky receive overrun |

## Verification
The assertions take several things as given about the inputs:
- Flush requests are single-cycle pulses.
- The overrun clear is driven only between events.
- The queue depth is a power of two, so the pointers wrap on their own.
- The inputs are settled well before each rising edge.

The stimulus keeps within these limits. It changes every input on the falling edge and samples on the next falling edge. It pulses each flush request for exactly one cycle. During a flush window it issues pushes, pops and a repeated request, which checks the ignore rule at the data output and at the level flags.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_DEPTH     = 16;
  localparam int unsigned DEF_THR_W     = 4;
  localparam int unsigned DEF_FLUSH_CYC = 4;

  typedef enum int unsigned {
    CH_TX = 0,
    CH_RX = 1
  } chan_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/fifo_flush_seq.sv
module fifo_flush_seq #(
  parameter int unsigned FLUSH_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic busy,
  output logic done
);
  localparam int unsigned CW   = $clog2(FLUSH_CYC + 1);
  localparam int unsigned LAST = FLUSH_CYC - 1;

  logic          busy_q;
  logic [CW-1:0] cyc_q;

  assign busy = busy_q;
  assign done = busy_q && (cyc_q == CW'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
    end else if (!busy_q) begin
      if (req) begin
        busy_q <= 1'b1;
        cyc_q  <= '0;
      end
    end else if (done) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      cyc_q <= cyc_q + CW'(1);
    end
  end

  AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (rst) busy_q |-> (cyc_q <= CW'(LAST))); // R8
  AST_FLUSH_SELFCLR: assert property (@(posedge clk) disable iff (rst) done |=> !busy_q); // R8
  AST_FLUSH_START: assert property (@(posedge clk) disable iff (rst) (!busy_q && req) |=> busy_q); // R8
endmodule

// File: rtl/fifo_level_core.sv
module fifo_level_core #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned THR_W    = 4,
  parameter bit          NEAR_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [THR_W-1:0]  thresh,
  input  logic              ovr_clr,
  output logic              empty,
  output logic              full,
  output logic              near,
  output logic              overrun
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt, cnt_nxt, thr_ext;
  logic              empty_q, full_q, near_q, ovr_q;
  logic [DATA_W-1:0] rd_q;
  logic              is_full, do_wr, do_rd, ovr_evt, near_nxt;

  assign is_full = (cnt == CW'(DEPTH));
  assign do_wr   = wr_en && !hold && !is_full;
  assign ovr_evt = wr_en && !hold && is_full;
  assign do_rd   = rd_en && !hold && (cnt != '0);
  assign thr_ext = CW'(thresh);

  always_comb begin
    case ({do_wr, do_rd})
      2'b10:   cnt_nxt = cnt + CW'(1);
      2'b01:   cnt_nxt = cnt - CW'(1);
      default: cnt_nxt = cnt;
    endcase
  end

  generate
    if (NEAR_LOW) begin : g_near_low
      assign near_nxt = (cnt_nxt != '0) && (cnt_nxt <= thr_ext);
    end else begin : g_near_high
      assign near_nxt = (cnt_nxt != '0) && (cnt_nxt >= thr_ext);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (do_rd) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      near_q  <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + AW'(1);
      if (do_rd) rptr <= rptr + AW'(1);
      cnt     <= cnt_nxt;
      empty_q <= (cnt_nxt == '0);
      full_q  <= (cnt_nxt == CW'(DEPTH));
      near_q  <= near_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovr_q <= 1'b0;
    else if (ovr_evt) ovr_q <= 1'b1;
    else if (ovr_clr) ovr_q <= 1'b0;
  end

  assign rd_data = rd_q;
  assign empty   = empty_q;
  assign full    = full_q;
  assign near    = near_q;
  assign overrun = ovr_q;

  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (rst) !(empty_q && full_q)); // R3
  AST_POP_EMPTY_IGN: assert property (@(posedge clk) disable iff (rst) (empty_q && rd_en && !wr_en) |=> empty_q); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst) (full_q && wr_en && !rd_en && !clear) |=> full_q); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) (ovr_q && !ovr_clr) |=> ovr_q); // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst) (hold && !clear) |=> ($stable(cnt) && $stable(rd_q))); // R9
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst) clear |=> (empty_q && !full_q && !near_q)); // R10
endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair
  import byte_fifo_pkg::*;
#(
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned DEPTH     = DEF_DEPTH,
  parameter int unsigned THR_W     = DEF_THR_W,
  parameter int unsigned FLUSH_CYC = DEF_FLUSH_CYC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [THR_W-1:0]  tx_thresh,
  input  logic [THR_W-1:0]  rx_thresh,
  input  logic              bus_tx_push,
  input  logic [DATA_W-1:0] bus_tx_data,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              bus_rx_pop,
  output logic [DATA_W-1:0] bus_rx_data,
  input  logic              flush_tx_req,
  input  logic              flush_rx_req,
  output logic              flush_tx_busy,
  output logic              flush_rx_busy,
  input  logic              ovr_clr,
  output logic              tx_empty,
  output logic              tx_near_empty,
  output logic              tx_full,
  output logic              tx_overrun,
  output logic              rx_empty,
  output logic              rx_near_full,
  output logic              rx_full,
  output logic              rx_overrun
);
  logic [NUM_CH-1:0] fl_req, fl_busy, fl_done;

  assign fl_req[CH_TX] = flush_tx_req;
  assign fl_req[CH_RX] = flush_rx_req;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_flush
      fifo_flush_seq #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
        .clk  (clk),
        .rst  (rst),
        .req  (fl_req[c]),
        .busy (fl_busy[c]),
        .done (fl_done[c])
      );
    end
  endgenerate

  assign flush_tx_busy = fl_busy[CH_TX];
  assign flush_rx_busy = fl_busy[CH_RX];

  fifo_level_core #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W), .NEAR_LOW(1'b1)
  ) u_tx (
    .clk     (clk),
    .rst     (rst),
    .hold    (fl_busy[CH_TX]),
    .clear   (fl_done[CH_TX]),
    .wr_en   (bus_tx_push),
    .wr_data (bus_tx_data),
    .rd_en   (eng_tx_pop),
    .rd_data (eng_tx_data),
    .thresh  (tx_thresh),
    .ovr_clr (ovr_clr),
    .empty   (tx_empty),
    .full    (tx_full),
    .near    (tx_near_empty),
    .overrun (tx_overrun)
  );

  fifo_level_core #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W), .NEAR_LOW(1'b0)
  ) u_rx (
    .clk     (clk),
    .rst     (rst),
    .hold    (fl_busy[CH_RX]),
    .clear   (fl_done[CH_RX]),
    .wr_en   (eng_rx_push),
    .wr_data (eng_rx_data),
    .rd_en   (bus_rx_pop),
    .rd_data (bus_rx_data),
    .thresh  (rx_thresh),
    .ovr_clr (ovr_clr),
    .empty   (rx_empty),
    .full    (rx_full),
    .near    (rx_near_full),
    .overrun (rx_overrun)
  );

  AST_FLUSH_ENDS_EMPTY: assert property (@(posedge clk) disable iff (rst) $fell(fl_busy[CH_TX]) |-> (tx_empty && !tx_near_empty && !tx_full)); // R10
  AST_RX_FLUSH_ENDS_EMPTY: assert property (@(posedge clk) disable iff (rst) $fell(fl_busy[CH_RX]) |-> (rx_empty && !rx_near_full && !rx_full)); // R10
endmodule

// File: tb/byte_fifo_pair_tb_top.sv
module byte_fifo_pair_tb_top;
  localparam int FLUSH_CYC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tx_thresh = 4'd2, rx_thresh = 4'd3;
  logic       bus_tx_push = 0, eng_tx_pop = 0, eng_rx_push = 0, bus_rx_pop = 0;
  logic [7:0] bus_tx_data = 0, eng_rx_data = 0;
  logic [7:0] eng_tx_data, bus_rx_data;
  logic       flush_tx_req = 0, flush_rx_req = 0, ovr_clr = 0;
  logic       flush_tx_busy, flush_rx_busy;
  logic       tx_empty, tx_near_empty, tx_full, tx_overrun;
  logic       rx_empty, rx_near_full, rx_full, rx_overrun;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  byte_fifo_pair #(.FLUSH_CYC(FLUSH_CYC)) dut_i (
    .clk(clk), .rst(rst), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
    .flush_tx_req(flush_tx_req), .flush_rx_req(flush_rx_req),
    .flush_tx_busy(flush_tx_busy), .flush_rx_busy(flush_rx_busy),
    .ovr_clr(ovr_clr),
    .tx_empty(tx_empty), .tx_near_empty(tx_near_empty), .tx_full(tx_full), .tx_overrun(tx_overrun),
    .rx_empty(rx_empty), .rx_near_full(rx_near_full), .rx_full(rx_full), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] b);
    bus_tx_push = 1; bus_tx_data = b; tick(); bus_tx_push = 0;
  endtask

  task automatic pop_tx(output logic [7:0] b);
    eng_tx_pop = 1; tick(); eng_tx_pop = 0; b = eng_tx_data;
  endtask

  task automatic push_rx(input logic [7:0] b);
    eng_rx_push = 1; eng_rx_data = b; tick(); eng_rx_push = 0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    bus_rx_pop = 1; tick(); bus_rx_pop = 0; b = bus_rx_data;
  endtask

  task automatic t_reset();
    chk("R1", "tx_empty", tx_empty, 1);
    chk("R1", "rx_empty", rx_empty, 1);
    chk("R1", "tx_full", tx_full, 0);
    chk("R1", "rx_full", rx_full, 0);
    chk("R1", "tx_near_empty", tx_near_empty, 0);
    chk("R1", "rx_near_full", rx_near_full, 0);
    chk("R1", "overrun", {tx_overrun, rx_overrun}, 0);
    chk("R1", "busy", {flush_tx_busy, flush_rx_busy}, 0);
  endtask

  task automatic t_order_and_near_empty();
    logic [7:0] v;
    push_tx(8'hA5); chk("R6", "near_empty occ1", tx_near_empty, 1);
    chk("R3", "tx_empty occ1", tx_empty, 0);
    push_tx(8'h3C); chk("R6", "near_empty occ2", tx_near_empty, 1);
    push_tx(8'h7E); chk("R6", "near_empty occ3", tx_near_empty, 0);
    pop_tx(v); chk("R2", "tx order 0", v, 8'hA5);
    pop_tx(v); chk("R2", "tx order 1", v, 8'h3C);
    pop_tx(v); chk("R2", "tx order 2", v, 8'h7E);
    chk("R3", "tx_empty after drain", tx_empty, 1);
    chk("R6", "near_empty at occ0", tx_near_empty, 0);
  endtask

  task automatic t_rx_levels();
    logic [7:0] v;
    push_rx(8'd0); push_rx(8'd1);
    chk("R7", "near_full occ2", rx_near_full, 0);
    push_rx(8'd2);
    chk("R7", "near_full occ3", rx_near_full, 1);
    for (int i = 3; i < 16; i++) push_rx(8'(i));
    chk("R3", "rx_full occ16", rx_full, 1);
    chk("R7", "near_full occ16", rx_near_full, 1);
    pop_rx(v); chk("R2", "rx first", v, 0);
    chk("R3", "rx_full occ15", rx_full, 0);
    for (int i = 1; i < 16; i++) begin
      pop_rx(v); chk("R2", "rx order", v, i);
    end
    chk("R3", "rx_empty", rx_empty, 1);
    pop_rx(v);
    chk("R3", "pop empty keeps empty", rx_empty, 1);
    chk("R3", "pop empty keeps data", v, 15);
    push_rx(8'h99); pop_rx(v);
    chk("R3", "after empty pop", v, 8'h99);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) push_tx(8'(8'h10 + i));
    chk("R3", "tx_full", tx_full, 1);
    chk("R5", "no overrun yet", tx_overrun, 0);
    push_tx(8'hEE);
    chk("R5", "overrun set", tx_overrun, 1);
    chk("R4", "still full", tx_full, 1);
    tick();
    chk("R5", "overrun sticky", tx_overrun, 1);
    bus_tx_push = 1; bus_tx_data = 8'hDD; eng_tx_pop = 1; tick();
    bus_tx_push = 0; eng_tx_pop = 0;
    chk("R4", "pop honoured with dropped push", eng_tx_data, 8'h10);
    chk("R4", "not full after pop", tx_full, 0);
    for (int i = 1; i < 16; i++) begin
      pop_tx(v); chk("R4", "contents unchanged", v, 8'h10 + i);
    end
    chk("R4", "empty after drain", tx_empty, 1);
    chk("R5", "rx overrun clear", rx_overrun, 0);
    ovr_clr = 1; tick(); ovr_clr = 0;
    chk("R5", "overrun cleared", tx_overrun, 0);
  endtask

  task automatic t_simultaneous_and_thresh();
    logic [7:0] v;
    push_tx(8'h01); push_tx(8'h02);
    bus_tx_push = 1; bus_tx_data = 8'h03; eng_tx_pop = 1; tick();
    bus_tx_push = 0; eng_tx_pop = 0;
    chk("R2", "simul pop data", eng_tx_data, 8'h01);
    chk("R2", "simul keeps occ2", tx_near_empty, 1);
    tx_thresh = 4'd1;
    chk("R11", "thresh not yet seen", tx_near_empty, 1);
    tick();
    chk("R11", "thresh seen after edge", tx_near_empty, 0);
    tx_thresh = 4'd2; tick();
    pop_tx(v); chk("R2", "simul order a", v, 8'h02);
    pop_tx(v); chk("R2", "simul order b", v, 8'h03);
  endtask

  task automatic t_flush();
    logic [7:0] v, held;
    for (int i = 0; i < 5; i++) push_tx(8'(8'h50 + i));
    for (int i = 0; i < 4; i++) push_rx(8'(8'h60 + i));
    held = eng_tx_data;
    flush_tx_req = 1; tick(); flush_tx_req = 0;
    chk("R8", "tx busy", flush_tx_busy, 1);
    chk("R8", "rx not busy", flush_rx_busy, 0);
    for (int i = 0; i < FLUSH_CYC - 1; i++) begin
      bus_tx_push = 1; bus_tx_data = 8'hFF; eng_tx_pop = 1; flush_tx_req = 1; tick();
      chk("R8", "busy held", flush_tx_busy, 1);
      chk("R9", "pop ignored", eng_tx_data, held);
      chk("R9", "level frozen", tx_near_empty, 0);
    end
    bus_tx_push = 0; eng_tx_pop = 0; flush_tx_req = 0;
    tick();
    chk("R8", "busy self-clears", flush_tx_busy, 0);
    chk("R10", "tx empty", tx_empty, 1);
    chk("R10", "tx full low", tx_full, 0);
    chk("R10", "tx near low", tx_near_empty, 0);
    tick();
    chk("R9", "repeat request ignored", flush_tx_busy, 0);
    chk("R8", "rx untouched", rx_near_full, 1);
    push_tx(8'h42); pop_tx(v);
    chk("R10", "fresh after flush", v, 8'h42);
    flush_rx_req = 1; tick(); flush_rx_req = 0;
    chk("R8", "rx busy", flush_rx_busy, 1);
    repeat (FLUSH_CYC) tick();
    chk("R8", "rx busy clears", flush_rx_busy, 0);
    chk("R10", "rx empty", rx_empty, 1);
    chk("R10", "rx near low", rx_near_full, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    t_reset();
    t_order_and_near_empty();
    t_rx_levels();
    t_overrun();
    t_simultaneous_and_thresh();
    t_flush();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule